// File: doc/BRIEF.md
# Dual-Rank Eight-Channel Converter Code Registers

This block is the digital front end of an eight-channel converter driven from a parallel bus. Each channel keeps two register ranks. A write places a 13-bit word in the first rank of one channel, picked by a 3-bit address. A shared load strobe copies every first-rank value into its second rank in the same cycle, so all channel codes change together. With the write and load strobes active at once, the bus word reaches the addressed channel's output code in a single clock.

All strobes are active-low levels, sampled on the rising edge of the system clock. The block has no back-pressure: it takes a write in every cycle where chip-select and write-strobe are both low, and a load in every cycle where the load strobe is low, so there is no valid/ready pair. A format pin selects whether a bus word is taken as offset binary or as two's complement. A two's complement word is turned into offset binary by adding 4096 modulo 8192. The address-to-channel mapping is a parameter table, so channel letters need not follow address order. A clear input raises one ground-select flag per channel. It leaves every register rank untouched.

Top module: `dac_dual_rank_regs`

## Requirements
- R1: After reset, every channel code is 0 and every ground-select flag is 0.
- R2: A write updates only the input rank of the channel given by the default map. Address 0 through 7 map to channels 3, 1, 0, 2, 6, 4, 7, 5. No other channel's input rank changes.
- R3: A channel's input rank changes only in a cycle where cs_n and wr_n are both sampled low. If either one is high, it holds.
- R4: While ld_n is sampled high, no channel code changes, even when writes take place.
- R5: In a cycle where cs_n, wr_n and ld_n are all sampled low, the addressed channel's code shows the bus word one clock later.
- R6: One cycle with ld_n low copies all eight input ranks to the codes at the same edge.
- R7: One clock after clr_n is sampled low, all eight ground-select flags are 1. The codes and the input ranks keep their values.
- R8: One clock after clr_n is sampled high again, the flags are 0. The codes still hold the values they had before the clear.
- R9: With twos_fmt at 1, the stored code is the bus word plus 4096 modulo 8192 (bit 12 inverted). With twos_fmt at 0, the word is stored unchanged.
- R10: The extreme codes 0x0000 and 0x1FFF pass through both ranks unchanged in offset-binary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe for the input rank |
| ld_n | input | 1 | Active-low load strobe for the output rank, shared by all channels |
| clr_n | input | 1 | Active-low clear to the ground reference |
| twos_fmt | input | 1 | 1: bus word is two's complement; 0: offset binary |
| addr | input | 3 | Channel address, decoded through the map table |
| data | input | 13 | Bus data word |
| dac_code | output | 104 | Eight 13-bit output codes; channel k sits at bits 13k+12 down to 13k |
| gnd_sel | output | 8 | Registered per-channel ground-select flag |

## Verification
Every address is written with walking-one, walking-zero, extreme and address-dependent words while the load strobe is held high. Holding the codes steady proves that the second rank is isolated. A single load pulse that moves all eight channels at once separates a simultaneous update from a per-channel one. Because the per-address words differ, any mix-up in the address map shows up as a wrong channel. Transparent writes with all strobes low, writes with one strobe high, and a clear laid over pending writes and loads separate the pass-through path, the strobe gating, and the rule that a clear masks without resetting. Both format settings are swept over the same words, and the expected codes are computed arithmetically.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int unsigned DAC_DW  = 13;
  localparam int unsigned DAC_NCH = 8;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } code_fmt_e;

  typedef struct packed {
    logic wr_go;
    logic ld_go;
    logic clr_go;
  } strobe_t;
endpackage

// File: rtl/dac_code_format.sv
module dac_code_format #(
  parameter int unsigned DW = dac_regs_pkg::DAC_DW
) (
  input  dac_regs_pkg::code_fmt_e fmt,
  input  logic [DW-1:0]           word_in,
  output logic [DW-1:0]           code_out
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  // adding half scale modulo full scale flips only the top bit
  always_comb begin
    if (fmt == dac_regs_pkg::FMT_TWOS) code_out = word_in ^ HALF;
    else                                code_out = word_in;
  end

  always_comb begin
    assert_fmt_msb_R9: assert ((code_out[DW-2:0] == word_in[DW-2:0]) || $isunknown(word_in))
      else $error("format stage altered low bits");
  end
endmodule

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int unsigned        NCH      = dac_regs_pkg::DAC_NCH,
  parameter int unsigned        AW       = $clog2(NCH),
  parameter logic [NCH*AW-1:0]  ADDR_MAP = 24'hBE640B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_go,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] wr_sel
);
  logic [AW-1:0] ch_idx;

  always_comb begin
    ch_idx = ADDR_MAP[addr*AW +: AW];
    wr_sel = '0;
    if (wr_go) wr_sel[ch_idx] = 1'b1;
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel))
    else $error("more than one channel selected for a write");

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |-> (wr_sel == '0))
    else $error("channel selected without a write strobe");
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DW = dac_regs_pkg::DAC_DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_sel,
  input  dac_regs_pkg::strobe_t stb,
  input  logic [DW-1:0]         word,
  output logic [DW-1:0]         code,
  output logic                  gnd_flag
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] in_next;
  logic [DW-1:0] out_q;

  // next first-rank value, also feeds the second rank so that all-low strobes pass straight through
  always_comb in_next = wr_sel ? word : in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q     <= '0;
      out_q    <= '0;
      gnd_flag <= 1'b0;
    end else begin
      in_q     <= in_next;
      if (stb.ld_go) out_q <= in_next;
      gnd_flag <= stb.clr_go;
    end
  end

  assign code = out_q;

  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(in_q))
    else $error("input rank moved without a write");

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ld_go |=> $stable(out_q))
    else $error("output rank moved without a load");

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && stb.ld_go) |=> (out_q == $past(word)))
    else $error("transparent write did not reach the output");

  assert_clear_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clr_go |=> gnd_flag)
    else $error("ground flag not raised by clear");

  assert_clear_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.clr_go |=> !gnd_flag)
    else $error("ground flag stuck after clear release");
endmodule

// File: rtl/dac_dual_rank_regs.sv
module dac_dual_rank_regs #(
  parameter int unsigned       NCH      = dac_regs_pkg::DAC_NCH,
  parameter int unsigned       DW       = dac_regs_pkg::DAC_DW,
  parameter int unsigned       AW       = $clog2(NCH),
  parameter logic [NCH*AW-1:0] ADDR_MAP = 24'hBE640B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            ld_n,
  input  logic            clr_n,
  input  logic            twos_fmt,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]  gnd_sel
);
  dac_regs_pkg::strobe_t   stb;
  dac_regs_pkg::code_fmt_e fmt;
  logic [DW-1:0]           word;
  logic [NCH-1:0]          wr_sel;

  always_comb begin
    stb.wr_go  = !cs_n && !wr_n;
    stb.ld_go  = !ld_n;
    stb.clr_go = !clr_n;
    fmt        = twos_fmt ? dac_regs_pkg::FMT_TWOS : dac_regs_pkg::FMT_OFFSET;
  end

  dac_code_format #(.DW(DW)) u_fmt (
    .fmt      (fmt),
    .word_in  (data),
    .code_out (word)
  );

  dac_addr_decode #(.NCH(NCH), .AW(AW), .ADDR_MAP(ADDR_MAP)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_go  (stb.wr_go),
    .addr   (addr),
    .wr_sel (wr_sel)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dac_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_sel[k]),
      .stb      (stb),
      .word     (word),
      .code     (dac_code[k*DW +: DW]),
      .gnd_flag (gnd_sel[k])
    );
  end

  assert_flags_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnd_sel == '0) || (gnd_sel == '1))
    else $error("ground flags disagree between channels");

  assert_load_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && clr_n) |=> $stable(dac_code))
    else $error("codes moved while load strobe was high");
endmodule

// File: tb/test_dac_dual_rank_regs.sv
module test_dac_dual_rank_regs;
  localparam int NCH = 8;
  localparam int DW  = 13;

  logic clk = 1'b0;
  logic rst_n, cs_n, wr_n, ld_n, clr_n, twos_fmt;
  logic [2:0]      addr;
  logic [DW-1:0]   data;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0]  gnd_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [DW-1:0] in_m  [NCH];
  logic [DW-1:0] out_m [NCH];
  logic          clr_m;

  always #5 clk = ~clk;

  dac_dual_rank_regs i_dac_dual_rank_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
    .clr_n(clr_n), .twos_fmt(twos_fmt), .addr(addr), .data(data),
    .dac_code(dac_code), .gnd_sel(gnd_sel)
  );

  // R2 map written out independently of the design
  function automatic int ch_of(input int a);
    case (a)
      0: return 3; 1: return 1; 2: return 0; 3: return 2;
      4: return 6; 5: return 4; 6: return 7; default: return 5;
    endcase
  endfunction

  // R9 arithmetic conversion
  function automatic logic [DW-1:0] conv(input logic [DW-1:0] d, input logic tw);
    int v;
    v = tw ? (int'(d) + 4096) % 8192 : int'(d);
    return v[DW-1:0];
  endfunction

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      tests++;
      if (dac_code[k*DW +: DW] !== out_m[k]) begin
        fails++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", req, k, dac_code[k*DW +: DW], out_m[k]);
      end
    end
    tests++;
    if (gnd_sel !== {NCH{clr_m}}) begin
      fails++;
      $display("FAIL %s gnd_sel actual=%b expected=%b", req, gnd_sel, {NCH{clr_m}});
    end
  endtask

  task automatic cycle(input logic c, input logic w, input logic l, input logic cl,
                       input int a, input logic [DW-1:0] d, input logic tw, input string req);
    @(negedge clk);
    cs_n = c; wr_n = w; ld_n = l; clr_n = cl; addr = a[2:0]; data = d; twos_fmt = tw;
    @(posedge clk);
    if (!c && !w) in_m[ch_of(a)] = conv(d, tw);
    if (!l) for (int k = 0; k < NCH; k++) out_m[k] = in_m[k];
    clr_m = !cl;
    #1 check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; clr_n = 1'b1;
    twos_fmt = 1'b0; addr = '0; data = '0;
    for (int k = 0; k < NCH; k++) begin in_m[k] = '0; out_m[k] = '0; end
    clr_m = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check_all("R1");

    // R2/R4/R6: both formats, several word patterns, staged then loaded together
    for (int tw = 0; tw < 2; tw++) begin
      for (int p = 0; p < 5; p++) begin
        for (int a = 0; a < NCH; a++) begin
          logic [DW-1:0] d;
          case (p)
            0: d = 13'(1 << a);
            1: d = ~13'(1 << (a + 5));
            2: d = 13'(a * 1000 + 7);
            3: d = 13'h0000;
            default: d = 13'h1FFF;
          endcase
          cycle(1'b0, 1'b0, 1'b1, 1'b1, a, d, tw[0], "R4 R2 R9");
        end
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 0, 13'h0, 1'b0, "R6 R10");
      end
    end

    // R3: one strobe high, no write, then load to expose input ranks
    for (int a = 0; a < NCH; a++) begin
      cycle(1'b1, 1'b0, 1'b1, 1'b1, a, 13'h0AAA, 1'b0, "R3 cs_n high");
      cycle(1'b0, 1'b1, 1'b1, 1'b1, a, 13'h1555, 1'b0, "R3 wr_n high");
    end
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 0, 13'h0, 1'b0, "R3 load");

    // R5: transparent path for every address
    for (int a = 0; a < NCH; a++)
      cycle(1'b0, 1'b0, 1'b0, 1'b1, a, 13'(a * 911 + 3), 1'b0, "R5");

    // R7: clear masks without reset; staged write and hold kept
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 0, 13'h0, 1'b0, "R7 assert");
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 2, 13'h0123, 1'b0, "R7 write under clear");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 0, 13'h0, 1'b0, "R7 hold");
    // R8: release, codes as before, then load shows the staged write
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 0, 13'h0, 1'b0, "R8 release");
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 0, 13'h0, 1'b0, "R8 load after clear");

    // R9/R10 extremes in both formats through transparent path
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 4, 13'h0000, 1'b1, "R9 twos zero");
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 4, 13'h1000, 1'b1, "R9 twos min");
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 4, 13'h0FFF, 1'b1, "R9 twos max");
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 7, 13'h1FFF, 1'b0, "R10 top");
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 7, 13'h0000, 1'b0, "R10 bottom");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule